// File: doc/BRIEF.md
# Parallel Port Enhanced Write Cycle Engine

This block converts a single host-side write request into a full enhanced-parallel-port write transfer to a peripheral. It works for both data and address transfers. When the host pulses its write request, the block captures the byte and the address/data select into a holding register. It drives the direction line to its write level and keeps the host stalled while it runs the port handshake with the peripheral.

The peripheral's busy/ready line comes in through a two-stage synchronizer and a settle filter. A ringing cable therefore cannot produce a false handshake edge. The command strobe goes low only once the filtered line reports ready. It is released once the filtered line reports that the peripheral has taken the byte, and at that point the host is let go. A cycle counter guards the whole handshake. If the peripheral stalls, the transfer is aborted and a sticky timeout flag is raised. While that flag is set, later host writes finish at once and do not touch the port. The settle interval and the timeout are both parameters in clock cycles. At 50 MHz the defaults are 3 cycles (60 ns, above the 50 ns minimum) and 500 cycles (10 us).

Top module: `epp_write_engine`

## Requirements
- R1: Out of reset, both command strobes and the direction line are high (inactive / read level), host_busy is low, tmo_flag is low, and the filtered ready line is taken as high (peripheral busy).
- R2: A change on port_wait_n is acted on only when, after two synchronizer stages, the new level has held for SETTLE_CYC consecutive clock cycles. With the default of 3, a pulse lasting 2 cycles has no effect on the strobes. A steady change is seen by the handshake at the 6th rising edge after the change.
- R3: When host_wr is sampled high while idle, host_wdata is captured. port_data then shows the captured byte for the whole transfer, even if host_wdata changes later.
- R4: port_write_n goes low at the first rising edge after the accepted request, at least two cycles before any strobe. It returns high when the transfer ends.
- R5: host_busy is high from the first rising edge after an accepted request until the transfer ends. Requests made while busy are ignored.
- R6: The command strobe goes low no earlier than the third rising edge after the request, and only while the filtered ready line is low. host_addr_sel = 1 selects port_astb_n and host_addr_sel = 0 selects port_dstb_n. Only the selected strobe ever goes low.
- R7: Once the filtered ready line goes high during a strobe, the strobe, port_write_n and host_busy all return to idle at the same edge.
- R8: If the filtered ready line is high when a transfer reaches the strobe phase, the strobe waits until it goes low.
- R9: If a transfer has not ended TMO_CYC cycles after its setup cycle, it is aborted. tmo_flag is set, and the strobes, port_write_n and host_busy return to idle. With the default of 500, the flag rises at the 502nd rising edge after the request.
- R10: While tmo_flag is high, a host request is accepted without effect: host_busy stays low, port_write_n and both strobes stay high.
- R11: A one-cycle pulse on tmo_clr clears tmo_flag at the next rising edge, after which transfers run normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| host_wr | input | 1 | Write request pulse from the host, one cycle |
| host_addr_sel | input | 1 | 1 = address transfer, 0 = data transfer |
| host_wdata | input | 8 | Byte to send |
| tmo_clr | input | 1 | Clears the sticky timeout flag |
| host_busy | output | 1 | Stalls the host while a transfer runs |
| tmo_flag | output | 1 | Sticky timeout status |
| port_wait_n | input | 1 | Peripheral busy/ready line, asynchronous, may ring |
| port_write_n | output | 1 | Direction line, low = write |
| port_data | output | 8 | Port data lines |
| port_dstb_n | output | 1 | Data command strobe, active low |
| port_astb_n | output | 1 | Address command strobe, active low |

## Verification
The assertions assume the host issues host_wr only as a single-cycle pulse and only while host_busy is low. They also assume port_wait_n changes at most once per clock, so the synchronized copy is a clean level. The bench drives every input at the falling edge and keeps each request to one cycle. It waits for the transfer to end before issuing the next one. Ringing is imitated only with whole-cycle pulses, shorter and longer than the settle interval, so that the handshake edges can be predicted to the exact cycle.

// File: rtl/epp_wr_pkg.sv
package epp_wr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_READY = 2'd2,
    ST_STRB  = 2'd3
  } epp_wr_st_e;
endpackage

// File: rtl/epp_wait_filter.sv
module epp_wait_filter #(
  parameter int SETTLE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_raw_n,
  output logic wait_filt_n
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic          sync1_q, sync2_q;
  logic          filt_q, filt_d;
  logic [SW-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (sync2_q == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q == SW'(SETTLE_CYC - 1)) begin
      filt_d = sync2_q;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      filt_q  <= 1'b1;
      cnt_q   <= '0;
    end else begin
      sync1_q <= wait_raw_n;
      sync2_q <= sync1_q;
      filt_q  <= filt_d;
      cnt_q   <= cnt_d;
    end
  end

  assign wait_filt_n = filt_q;

  // R2
  filt_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> ($past(sync2_q) == filt_q));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < SW'(SETTLE_CYC));
endmodule

// File: rtl/epp_stall_timer.sv
module epp_stall_timer #(
  parameter int TMO_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(TMO_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = run && (cnt_q == CW'(TMO_CYC - 1));
  assign cnt_en  = start || (run && !expired);

  always_comb begin
    cnt_d = cnt_q;
    if (start)        cnt_d = '0;
    else if (cnt_en)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R9
  tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(TMO_CYC - 1));
endmodule

// File: rtl/epp_wr_fsm.sv
module epp_wr_fsm #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_addr_sel,
  input  logic [DW-1:0] host_wdata,
  input  logic          tmo_clr,
  input  logic          wait_filt_n,
  input  logic          tmr_expired,
  output logic          tmr_start,
  output logic          tmr_run,
  output logic          busy,
  output logic          tmo_flag,
  output logic          write_n,
  output logic [DW-1:0] data,
  output logic          dstb_n,
  output logic          astb_n
);
  import epp_wr_pkg::*;

  epp_wr_st_e    st_q, st_d;
  logic          sel_q, sel_d;
  logic [DW-1:0] data_q;
  logic          tmo_q, tmo_d;
  logic          wrn_q, wrn_d;
  logic          dstb_q, dstb_d;
  logic          astb_q, astb_d;
  logic          accept, abort;

  assign accept = (st_q == ST_IDLE) && host_wr && !tmo_q;

  always_comb begin
    st_d  = st_q;
    abort = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_SETUP;
      ST_SETUP: st_d = ST_READY;
      ST_READY: begin
        if (!wait_filt_n)     st_d = ST_STRB;
        else if (tmr_expired) begin st_d = ST_IDLE; abort = 1'b1; end
      end
      ST_STRB: begin
        if (wait_filt_n)      st_d = ST_IDLE;
        else if (tmr_expired) begin st_d = ST_IDLE; abort = 1'b1; end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    sel_d  = accept ? host_addr_sel : sel_q;
    tmo_d  = abort ? 1'b1 : (tmo_clr ? 1'b0 : tmo_q);
    wrn_d  = (st_d == ST_IDLE);
    dstb_d = !((st_d == ST_STRB) && !sel_d);
    astb_d = !((st_d == ST_STRB) && sel_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sel_q  <= 1'b0;
      tmo_q  <= 1'b0;
      wrn_q  <= 1'b1;
      dstb_q <= 1'b1;
      astb_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      tmo_q  <= tmo_d;
      wrn_q  <= wrn_d;
      dstb_q <= dstb_d;
      astb_q <= astb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (accept) data_q <= host_wdata;
  end

  assign tmr_start = (st_q == ST_SETUP);
  assign tmr_run   = (st_q == ST_READY) || (st_q == ST_STRB);
  assign busy      = (st_q != ST_IDLE);
  assign tmo_flag  = tmo_q;
  assign write_n   = wrn_q;
  assign data      = data_q;
  assign dstb_n    = dstb_q;
  assign astb_n    = astb_q;

  // R6
  strobe_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(dstb_q && astb_q) && $past(dstb_q && astb_q)) |-> !$past(wait_filt_n));

  // R4
  write_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(dstb_q && astb_q) && $past(dstb_q && astb_q)) |-> !$past(wrn_q));

  // R7
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dstb_q && astb_q) && !$past(dstb_q && astb_q)) |-> ($past(wait_filt_n) || tmo_q));

  // R3
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrn_q && $past(!wrn_q)) |-> $stable(data_q));

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~dstb_q, ~astb_q}) <= 1);

  // R10
  quiet_on_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && $past(tmo_q)) |-> (dstb_q && astb_q && wrn_q));
endmodule

// File: rtl/epp_write_engine.sv
module epp_write_engine #(
  parameter int DW         = 8,
  parameter int SETTLE_CYC = 3,
  parameter int TMO_CYC    = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_addr_sel,
  input  logic [DW-1:0] host_wdata,
  input  logic          tmo_clr,
  output logic          host_busy,
  output logic          tmo_flag,
  input  logic          port_wait_n,
  output logic          port_write_n,
  output logic [DW-1:0] port_data,
  output logic          port_dstb_n,
  output logic          port_astb_n
);
  logic wait_filt_n;
  logic tmr_start, tmr_run, tmr_expired;

  epp_wait_filter #(.SETTLE_CYC(SETTLE_CYC)) u_filt (
    .clk         (clk),
    .rst_n       (rst_n),
    .wait_raw_n  (port_wait_n),
    .wait_filt_n (wait_filt_n)
  );

  epp_stall_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .run     (tmr_run),
    .expired (tmr_expired)
  );

  epp_wr_fsm #(.DW(DW)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr       (host_wr),
    .host_addr_sel (host_addr_sel),
    .host_wdata    (host_wdata),
    .tmo_clr       (tmo_clr),
    .wait_filt_n   (wait_filt_n),
    .tmr_expired   (tmr_expired),
    .tmr_start     (tmr_start),
    .tmr_run       (tmr_run),
    .busy          (host_busy),
    .tmo_flag      (tmo_flag),
    .write_n       (port_write_n),
    .data          (port_data),
    .dstb_n        (port_dstb_n),
    .astb_n        (port_astb_n)
  );

  // R5
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_busy) |-> (port_dstb_n && port_astb_n && port_write_n));

  // R9
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> (!host_busy && port_dstb_n && port_astb_n));
endmodule

// File: tb/tb_epp_write_engine.sv
module tb_epp_write_engine;
  localparam int TMO = 500;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_addr_sel = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic       tmo_clr = 1'b0;
  logic       port_wait_n = 1'b1;
  logic       host_busy, tmo_flag, port_write_n, port_dstb_n, port_astb_n;
  logic [7:0] port_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  epp_write_engine #(.DW(8), .SETTLE_CYC(3), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr_sel(host_addr_sel),
    .host_wdata(host_wdata), .tmo_clr(tmo_clr), .host_busy(host_busy),
    .tmo_flag(tmo_flag), .port_wait_n(port_wait_n), .port_write_n(port_write_n),
    .port_data(port_data), .port_dstb_n(port_dstb_n), .port_astb_n(port_astb_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // request pulse; returns at the first falling edge after it was sampled
  task automatic request(input logic sel, input logic [7:0] d);
    host_wr = 1'b1; host_addr_sel = sel; host_wdata = d;
    nclk(1);
    host_wr = 1'b0; host_wdata = ~d;
  endtask

  // peripheral acknowledge while strobe low; strobe releases at 6th edge
  task automatic ack(input string tag);
    port_wait_n = 1'b1;
    nclk(5);
    chk({tag, " R2 strobe held before settle"}, port_dstb_n & port_astb_n, 1'b0);
    nclk(1);
    chk({tag, " R7 strobes released"}, {port_dstb_n, port_astb_n}, 2'b11);
    chk({tag, " R7 busy released"}, host_busy, 1'b0);
    chk({tag, " R4 write_n back high"}, port_write_n, 1'b1);
    port_wait_n = 1'b0;
    nclk(8);
  endtask

  task automatic t_reset;
    nclk(1);
    chk("R1 strobes", {port_dstb_n, port_astb_n}, 2'b11);
    chk("R1 write_n", port_write_n, 1'b1);
    chk("R1 busy", host_busy, 1'b0);
    chk("R1 tmo", tmo_flag, 1'b0);
  endtask

  task automatic t_write(input logic sel, input logic [7:0] d, input string tag);
    request(sel, d);
    chk({tag, " R5 busy"}, host_busy, 1'b1);
    chk({tag, " R4 write_n low"}, port_write_n, 1'b0);
    chk({tag, " R3 data"}, port_data, d);
    nclk(1);
    chk({tag, " R6 no strobe yet"}, {port_dstb_n, port_astb_n}, 2'b11);
    nclk(1);
    chk({tag, " R6 strobe select"}, {port_dstb_n, port_astb_n}, sel ? 2'b10 : 2'b01);
    chk({tag, " R3 data held"}, port_data, d);
    ack(tag);
  endtask

  task automatic t_glitch;
    request(1'b0, 8'h5A);
    nclk(2);
    chk("R6 glitch strobe", port_dstb_n, 1'b0);
    port_wait_n = 1'b1; nclk(2); port_wait_n = 1'b0;
    nclk(12);
    chk("R2 glitch ignored", port_dstb_n, 1'b0);
    chk("R2 glitch busy", host_busy, 1'b1);
    ack("glitch");
  endtask

  task automatic t_ready_wait;
    port_wait_n = 1'b1; nclk(8);
    request(1'b1, 8'hC3);
    nclk(19);
    chk("R8 strobe waits", port_astb_n, 1'b1);
    chk("R8 still busy", host_busy, 1'b1);
    port_wait_n = 1'b0;
    nclk(5);
    chk("R8 strobe before settle", port_astb_n, 1'b1);
    nclk(1);
    chk("R8 strobe after ready", port_astb_n, 1'b0);
    chk("R3 data held long", port_data, 8'hC3);
    ack("ready");
  endtask

  task automatic t_timeout;
    port_wait_n = 1'b1; nclk(8);
    request(1'b0, 8'h11);
    nclk(TMO);
    chk("R9 no flag early", tmo_flag, 1'b0);
    chk("R9 busy before abort", host_busy, 1'b1);
    nclk(1);
    chk("R9 flag set", tmo_flag, 1'b1);
    chk("R9 busy dropped", host_busy, 1'b0);
    chk("R9 idle port", {port_write_n, port_dstb_n, port_astb_n}, 3'b111);
    port_wait_n = 1'b0; nclk(8);
    request(1'b0, 8'h22);
    for (int i = 0; i < 6; i++) begin
      chk("R10 ignored busy", host_busy, 1'b0);
      chk("R10 ignored port", {port_write_n, port_dstb_n, port_astb_n}, 3'b111);
      nclk(1);
    end
    chk("R10 flag sticky", tmo_flag, 1'b1);
    tmo_clr = 1'b1; nclk(1); tmo_clr = 1'b0;
    chk("R11 flag cleared", tmo_flag, 1'b0);
    t_write(1'b0, 8'h77, "after clear R11");
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    nclk(3);
    t_reset();
    rst_n = 1'b1;
    port_wait_n = 1'b0;
    nclk(8);
    t_write(1'b0, 8'hA5, "data");
    t_write(1'b1, 8'h3C, "addr");
    t_glitch();
    t_ready_wait();
    t_timeout();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule